// File: doc/BRIEF.md
# Resynchronization Clock Phase Window Finder

This block searches for the best sampling phase of the clock that re-times data leaving the strobe-clocked capture flops. After a start pulse it walks a phase index through two full clock periods, one step at a time. At each step it waits a fixed settling time, asks the surrounding logic to read back the training pattern, and takes a single pass/fail verdict through a request/valid handshake. The phase shifter is represented here only by the phase index it is given.

Because the sweep covers twice the period, a passing window that crosses the wrap of the phase index appears as one unbroken run of passes. The block keeps the longest run as it goes. When the sweep ends it picks the step at the centre of that run, reduced modulo the number of steps per period, and leaves the phase index on that step. If no step passes, it raises a failure flag and returns the phase index to zero. The number of steps per period is an input, checked against a compile-time maximum.

Top module: `psw_window_finder`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `phase_sel`=0, `phase_chosen`=0, `done`=0, `fail`=0 and `sample_req`=0.
- R2: `start` is accepted only when the block is idle and `steps_n` is between 1 and MAX_STEPS. Acceptance clears `done` and `fail` and sets `phase_sel` to 0. A start with `steps_n` of 0 or above MAX_STEPS has no effect.
- R3: Each time the phase index is set, `sample_req` rises exactly SETTLE_CYCLES cycles later. It stays high until a cycle with `cmp_valid`=1, and it is low in the cycle after that.
- R4: Each result taken while `sample_req` is high advances `phase_sel` by one, wrapping from `steps_n`-1 to 0. The sweep takes exactly 2×`steps_n` results, recorded as steps 0 to 2×`steps_n`-1.
- R5: `cmp_valid` is ignored whenever `sample_req` is low.
- R6: The chosen phase is (S + floor((L-1)/2)) mod `steps_n`, where L is the length of the longest run of consecutive passing steps and S is the step where that run begins.
- R7: A passing window that crosses the phase-index wrap is measured as one run across the step boundary between the two periods.
- R8: Among runs of equal greatest length, the one that starts earliest is used.
- R9: When no step passes, `fail`=1, `phase_chosen`=0 and `phase_sel`=0.
- R10: One cycle after the last result, `done` rises and `phase_sel` equals `phase_chosen`. Both results, and `done`, then hold until the next accepted start.
- R11: `start` during a sweep has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (pulse) |
| steps_n | input | $clog2(MAX_STEPS+1) | Phase steps per clock period |
| sample_req | output | 1 | Phase has settled; a pattern compare result is wanted |
| cmp_valid | input | 1 | Compare result is present |
| cmp_pass | input | 1 | Compare result: 1 = read data matched the pattern |
| phase_sel | output | $clog2(MAX_STEPS) | Phase index driven to the shifter |
| phase_chosen | output | $clog2(MAX_STEPS) | Centre of the widest passing window |
| done | output | 1 | Sweep finished; results valid |
| fail | output | 1 | No phase step passed |

## Verification
The bound checker watches, on every cycle, the rules that involve only the ports. These are the reset values, the request dropping after a result is taken, and the phase index moving only by one step or back to zero during a sweep. It also checks that `phase_sel` equals the chosen phase when `done` rises, that a failure always reports phase zero, and that results stay frozen while `done` is high. Whether the chosen phase is truly the centre of the longest run, and how wrapping windows, ties, short step counts, ignored starts and stray results are handled, can only be shown by the bench. It feeds chosen pass patterns to the block and compares every output on every clock against a behavioural model.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_SETTLE = 2'd1,
    PS_SAMPLE = 2'd2,
    PS_FINISH = 2'd3
  } psw_state_e;
endpackage

// File: rtl/psw_run_tracker.sv
// Online longest-run search over the stream of per-step verdicts.
module psw_run_tracker #(
  parameter int SW = 5,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          upd,
  input  logic          pass,
  input  logic [SW-1:0] step,
  output logic [LW-1:0] best_len,
  output logic [SW-1:0] best_start
);
  logic [LW-1:0] run_len_q;
  logic [SW-1:0] run_start_q;
  logic [LW-1:0] best_len_q;
  logic [SW-1:0] best_start_q;
  logic [LW-1:0] grow_len;
  logic [SW-1:0] grow_start;

  always_comb begin
    grow_len   = run_len_q + 1'b1;
    grow_start = (run_len_q == '0) ? step : run_start_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_len_q    <= '0;
      run_start_q  <= '0;
      best_len_q   <= '0;
      best_start_q <= '0;
    end else if (upd) begin
      if (pass) begin
        run_len_q   <= grow_len;
        run_start_q <= grow_start;
        // strict compare keeps the earliest of equal-length runs (R8)
        if (grow_len > best_len_q) begin
          best_len_q   <= grow_len;
          best_start_q <= grow_start;
        end
      end else begin
        run_len_q <= '0;
      end
    end
  end

  assign best_len   = best_len_q;
  assign best_start = best_start_q;
endmodule

// File: rtl/psw_center.sv
// Midpoint of the best run, folded back into one clock period.
module psw_center #(
  parameter int PW = 4,
  parameter int CW = 5,
  parameter int SW = 5,
  parameter int LW = 6
) (
  input  logic [LW-1:0] best_len,
  input  logic [SW-1:0] best_start,
  input  logic [CW-1:0] n_steps,
  output logic [PW-1:0] center
);
  localparam int EW = LW + 1;

  logic [LW-1:0] len_m1;
  logic [EW-1:0] half;
  logic [EW-1:0] raw;
  logic [EW-1:0] n_ext;
  logic [EW-1:0] folded;

  always_comb begin
    len_m1 = best_len - 1'b1;
    half   = EW'(len_m1 >> 1);
    raw    = EW'(best_start) + half;
    n_ext  = EW'(n_steps);
    // raw never reaches 2*n_steps, so one subtraction suffices
    folded = (raw >= n_ext) ? (raw - n_ext) : raw;
    center = PW'(folded);
  end
endmodule

// File: rtl/psw_seq.sv
// Sweep sequencer: phase index, settle timer, step count, result registers.
module psw_seq
  import psw_pkg::*;
#(
  parameter int MAX_STEPS     = 16,
  parameter int SETTLE_CYCLES = 3,
  parameter int PW            = 4,
  parameter int CW            = 5,
  parameter int SW            = 5,
  parameter int LW            = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] steps_n,
  input  logic          cmp_valid,
  input  logic [LW-1:0] best_len,
  input  logic [PW-1:0] center,
  output logic          trk_clear,
  output logic          trk_upd,
  output logic [SW-1:0] step_idx,
  output logic [CW-1:0] n_steps,
  output logic          sample_req,
  output logic [PW-1:0] phase_sel,
  output logic [PW-1:0] phase_chosen,
  output logic          done,
  output logic          fail
);
  localparam int TW = $clog2(SETTLE_CYCLES + 1);
  localparam int EW = LW + 1;

  psw_state_e    state_q;
  logic [TW-1:0] settle_q;
  logic [SW-1:0] step_q;
  logic [CW-1:0] n_q;
  logic [PW-1:0] phase_q;
  logic [PW-1:0] chosen_q;
  logic          done_q;
  logic          fail_q;

  logic start_ok;
  logic settle_end;
  logic last_step;
  logic phase_wrap;
  logic no_pass;

  always_comb begin
    start_ok   = start && (state_q == PS_IDLE) && (steps_n != '0) &&
                 (steps_n <= CW'(MAX_STEPS));
    settle_end = (settle_q == TW'(SETTLE_CYCLES - 1));
    last_step  = (EW'(step_q) == ((EW'(n_q) << 1) - EW'(1)));
    phase_wrap = ((EW'(phase_q) + EW'(1)) == EW'(n_q));
    no_pass    = (best_len == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PS_IDLE;
      settle_q <= '0;
      step_q   <= '0;
      n_q      <= '0;
      phase_q  <= '0;
      chosen_q <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      case (state_q)
        PS_IDLE: begin
          if (start_ok) begin
            n_q      <= steps_n;
            step_q   <= '0;
            phase_q  <= '0;
            settle_q <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            state_q  <= PS_SETTLE;
          end
        end
        PS_SETTLE: begin
          if (settle_end) state_q <= PS_SAMPLE;
          else            settle_q <= settle_q + 1'b1;
        end
        PS_SAMPLE: begin
          if (cmp_valid) begin
            if (last_step) begin
              state_q <= PS_FINISH;
            end else begin
              step_q   <= step_q + 1'b1;
              phase_q  <= phase_wrap ? '0 : (phase_q + 1'b1);
              settle_q <= '0;
              state_q  <= PS_SETTLE;
            end
          end
        end
        PS_FINISH: begin
          done_q   <= 1'b1;
          fail_q   <= no_pass;
          chosen_q <= no_pass ? '0 : center;
          phase_q  <= no_pass ? '0 : center;
          state_q  <= PS_IDLE;
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  assign trk_clear    = start_ok;
  assign trk_upd      = (state_q == PS_SAMPLE) && cmp_valid;
  assign step_idx     = step_q;
  assign n_steps      = n_q;
  assign sample_req   = (state_q == PS_SAMPLE);
  assign phase_sel    = phase_q;
  assign phase_chosen = chosen_q;
  assign done         = done_q;
  assign fail         = fail_q;
endmodule

// File: rtl/psw_window_finder.sv
module psw_window_finder #(
  parameter  int MAX_STEPS     = 16,
  parameter  int SETTLE_CYCLES = 3,
  localparam int PW            = $clog2(MAX_STEPS),
  localparam int CW            = $clog2(MAX_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] steps_n,
  output logic          sample_req,
  input  logic          cmp_valid,
  input  logic          cmp_pass,
  output logic [PW-1:0] phase_sel,
  output logic [PW-1:0] phase_chosen,
  output logic          done,
  output logic          fail
);
  localparam int SW = $clog2(2 * MAX_STEPS);
  localparam int LW = $clog2(2 * MAX_STEPS + 1);

  logic          trk_clear;
  logic          trk_upd;
  logic [SW-1:0] step_idx;
  logic [CW-1:0] n_steps;
  logic [LW-1:0] best_len;
  logic [SW-1:0] best_start;
  logic [PW-1:0] center;

  psw_seq #(
    .MAX_STEPS(MAX_STEPS), .SETTLE_CYCLES(SETTLE_CYCLES),
    .PW(PW), .CW(CW), .SW(SW), .LW(LW)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .steps_n(steps_n),
    .cmp_valid(cmp_valid), .best_len(best_len), .center(center),
    .trk_clear(trk_clear), .trk_upd(trk_upd), .step_idx(step_idx),
    .n_steps(n_steps), .sample_req(sample_req), .phase_sel(phase_sel),
    .phase_chosen(phase_chosen), .done(done), .fail(fail)
  );

  psw_run_tracker #(.SW(SW), .LW(LW)) u_trk (
    .clk(clk), .rst(rst), .clear(trk_clear), .upd(trk_upd),
    .pass(cmp_pass), .step(step_idx),
    .best_len(best_len), .best_start(best_start)
  );

  psw_center #(.PW(PW), .CW(CW), .SW(SW), .LW(LW)) u_ctr (
    .best_len(best_len), .best_start(best_start),
    .n_steps(n_steps), .center(center)
  );
endmodule

// File: rtl/psw_checker.sv
module psw_checker #(
  parameter  int MAX_STEPS = 16,
  localparam int PW        = $clog2(MAX_STEPS)
) (
  input logic          clk,
  input logic          rst,
  input logic          sample_req,
  input logic          cmp_valid,
  input logic [PW-1:0] phase_sel,
  input logic [PW-1:0] phase_chosen,
  input logic          done,
  input logic          fail
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (phase_sel == '0 && phase_chosen == '0 && !done && !fail && !sample_req));

  assert_req_drops_R3: assert property (@(posedge clk) disable iff (rst)
    (sample_req && cmp_valid) |=> !sample_req);

  assert_phase_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(phase_sel) && !done) |->
      (phase_sel == $past(phase_sel) + 1'b1 || phase_sel == '0));

  assert_fail_phase_zero_R9: assert property (@(posedge clk) disable iff (rst)
    fail |-> (done && phase_chosen == '0 && phase_sel == '0));

  assert_done_lands_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (phase_sel == phase_chosen && !sample_req));

  assert_results_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> ($stable(phase_chosen) && $stable(phase_sel) && $stable(fail)));
endmodule

bind psw_window_finder psw_checker #(.MAX_STEPS(MAX_STEPS)) u_chk (
  .clk(clk), .rst(rst), .sample_req(sample_req), .cmp_valid(cmp_valid),
  .phase_sel(phase_sel), .phase_chosen(phase_chosen), .done(done), .fail(fail)
);

// File: tb/psw_window_finder_bench.sv
`timescale 1ns/1ps
module psw_window_finder_bench;
  localparam int MAXS = 16;
  localparam int SET  = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [4:0] steps_n = 5'd16;
  logic       cmp_valid = 1'b0;
  logic       cmp_pass = 1'b0;
  logic       sample_req;
  logic [3:0] phase_sel;
  logic [3:0] phase_chosen;
  logic       done;
  logic       fail;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  psw_window_finder #(.MAX_STEPS(MAXS), .SETTLE_CYCLES(SET)) u_psw_window_finder (
    .clk(clk), .rst(rst), .start(start), .steps_n(steps_n),
    .sample_req(sample_req), .cmp_valid(cmp_valid), .cmp_pass(cmp_pass),
    .phase_sel(phase_sel), .phase_chosen(phase_chosen), .done(done), .fail(fail)
  );

  // ---------------- behavioural reference ----------------
  int m_mode = 0;      // 0 idle, 1 waiting for settle, 2 asking, 3 wrapping up
  int m_wait = 0;
  int m_step = 0;
  int m_n = 1;
  int m_phase = 0;
  int m_chosen = 0;
  bit m_done = 0;
  bit m_fail = 0;
  bit verdicts[$];

  function automatic void pick(output int mid, output bit none);
    int best = 0, best_at = 0, cur = 0, cur_at = 0;
    foreach (verdicts[i]) begin
      if (verdicts[i]) begin
        if (cur == 0) cur_at = i;
        cur++;
        if (cur > best) begin best = cur; best_at = cur_at; end
      end else cur = 0;
    end
    none = (best == 0);
    mid  = none ? 0 : (best_at + (best - 1) / 2) % m_n;
  endfunction

  always @(posedge clk) begin
    int mid;
    bit none;
    if (rst) begin
      m_mode = 0; m_wait = 0; m_step = 0; m_phase = 0;
      m_chosen = 0; m_done = 0; m_fail = 0;
    end else begin
      case (m_mode)
        0: if (start && steps_n >= 1 && steps_n <= MAXS) begin
             m_n = steps_n; m_done = 0; m_fail = 0; m_phase = 0;
             m_step = 0; m_wait = 0; verdicts.delete(); m_mode = 1;
           end
        1: if (m_wait == SET - 1) m_mode = 2; else m_wait++;
        2: if (cmp_valid) begin
             verdicts.push_back(cmp_pass);
             if (m_step == 2 * m_n - 1) m_mode = 3;
             else begin
               m_step++; m_phase = (m_phase + 1) % m_n; m_wait = 0; m_mode = 1;
             end
           end
        default: begin
          pick(mid, none);
          m_done = 1; m_fail = none; m_chosen = mid; m_phase = mid; m_mode = 0;
        end
      endcase
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit bad = 0;
    checks++;
    if (phase_sel !== 4'(m_phase)) begin
      bad = 1; $display("FAIL R4 phase_sel actual=%0d expected=%0d", phase_sel, m_phase);
    end
    if (sample_req !== (m_mode == 2)) begin
      bad = 1; $display("FAIL R3 sample_req actual=%0b expected=%0b", sample_req, m_mode == 2);
    end
    if (done !== m_done) begin
      bad = 1; $display("FAIL R10 done actual=%0b expected=%0b", done, m_done);
    end
    if (fail !== m_fail) begin
      bad = 1; $display("FAIL R9 fail actual=%0b expected=%0b", fail, m_fail);
    end
    if (phase_chosen !== 4'(m_chosen)) begin
      bad = 1; $display("FAIL R6 phase_chosen actual=%0d expected=%0d", phase_chosen, m_chosen);
    end
    if (bad) fails++;
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sweep(input int n, input logic [63:0] pat, input int dly_max,
                       input bit stray, input bit restart_mid);
    @(negedge clk); steps_n = 5'(n); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 2 * n; i++) begin
      while (!sample_req) @(negedge clk);
      repeat (i % (dly_max + 1)) @(negedge clk);
      cmp_valid = 1'b1; cmp_pass = pat[i];
      @(negedge clk);
      if (stray) begin
        cmp_pass = ~pat[i];            // R5: lands while the phase settles
        @(negedge clk);
      end
      cmp_valid = 1'b0;
      if (restart_mid && i == 3) begin  // R11: start in the middle of a sweep
        start = 1'b1; steps_n = 5'd7;
        @(negedge clk);
        start = 1'b0; steps_n = 5'(n);
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_result(input string tag, input int exp_phase, input bit exp_fail);
    check({tag, " phase_chosen"}, phase_chosen, exp_phase);
    check("R10 done after sweep", done, 1);
    check("R10 phase_sel on chosen", phase_sel, exp_phase);
    check("R9 fail flag", fail, exp_fail);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 phase_sel in reset", phase_sel, 0);
    check("R1 done in reset", done, 0);
    check("R1 sample_req in reset", sample_req, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // single window at steps 3..9, stray results during settle: centre 6
    sweep(16, 64'h0000_0000_0000_03F8, 0, 1'b1, 1'b0);
    expect_result("R6 R5", 6, 1'b0);

    // window over phases 14..3 crossing the wrap; longest run is steps 14..19
    sweep(16, 64'h0000_0000_C00F_C00F, 2, 1'b0, 1'b0);
    expect_result("R7", 0, 1'b0);

    // two runs of length 4 (steps 2..5 and 20..23), restart attempted mid-sweep
    sweep(16, 64'h0000_0000_00F0_003C, 1, 1'b0, 1'b1);
    expect_result("R8 R11", 3, 1'b0);

    // nothing passes
    sweep(16, 64'h0, 0, 1'b0, 1'b0);
    expect_result("R9", 0, 1'b1);

    // five steps per period, all ten steps pass: centre 4
    sweep(5, 64'h0000_0000_0000_03FF, 1, 1'b0, 1'b0);
    expect_result("R4", 4, 1'b0);

    // five steps, best run at steps 7..9 ending the sweep: 8 mod 5 = 3
    sweep(5, 64'h0000_0000_0000_0386, 0, 1'b0, 1'b0);
    expect_result("R6 wrap", 3, 1'b0);

    // out-of-range step counts must not start a sweep
    @(negedge clk); steps_n = 5'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (SET + 2) @(negedge clk);
    check("R2 zero count ignored: done", done, 1);
    check("R2 zero count ignored: sample_req", sample_req, 0);
    @(negedge clk); steps_n = 5'd17; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (SET + 2) @(negedge clk);
    check("R2 oversize count ignored: done", done, 1);
    check("R2 oversize count ignored: phase_sel", phase_sel, 3);

    // accepted start clears the results flags
    @(negedge clk); steps_n = 5'd4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 start clears done", done, 0);
    check("R2 start zeroes phase_sel", phase_sel, 0);
    repeat (SET) @(negedge clk);
    check("R3 request after settle", sample_req, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-sweep", sample_req, 0);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule